// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Critical-Word Forwarding

This block is a small direct-mapped cache between a processor request port and a slower word-wide main-memory port. The processor issues ordinary reads and writes to main-memory word addresses and does not need to know that the cache exists. The controller looks up the addressed word in its tag store. A read hit is answered from local storage. A read miss brings the whole four-word block into the line, starting at word 0 and working upward. The requested word is handed to the processor in the cycle after it arrives, while the rest of the block is still being fetched.

A compile-time parameter selects the write policy. In write-through mode, a write hit updates the line and also issues the same write to memory. In write-back mode, a write hit updates only the line and marks it modified. A modified line that is displaced by a read miss is first copied back to memory word by word, and only then does the new fill begin. Lines that were never modified are overwritten without any memory traffic. A write that misses goes straight to memory, and the line is left untouched. Only one processor request is in flight at a time.

Top module: `lt_cache`

## Requirements
- R1: A read to a word whose block is resident returns that word's current value with the response pulse one cycle after acceptance, and issues no memory request.
- R2: A read miss issues exactly four memory reads to the block containing the address, at word offsets 0, 1, 2, 3 in that order (offset = address bits [1:0], line index = bits [5:2], tag = bits [9:6]).
- R3: During a fill, the response pulse carries the requested word in the cycle after the memory beat whose offset matches the request arrives. The fill then continues, and the request port stays not-ready until the last beat has been stored.
- R4: With WRITE_BACK=0, a write hit updates the line and issues one memory write of the same address and data. The response follows the acceptance of that memory write.
- R5: With WRITE_BACK=1, a write hit updates only the line, issues no memory request, responds one cycle after acceptance, and marks the line modified.
- R6: A read miss that displaces a modified line first writes the four old words to their old addresses at offsets 0 to 3, then performs the fill.
- R7: A read miss that displaces an unmodified line, and any miss in write-through mode, issues no memory write.
- R8: A write miss issues one memory write with the request's address and data, issues no memory read, and does not allocate, so a later read of that address misses.
- R9: Only one request is outstanding. The request port is not-ready while any memory request is pending. A memory request that is not accepted holds its address and direction.
- R10: After reset every line is invalid and the request port is ready with no response pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller accepts a request this cycle |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read data, valid with the pulse on reads |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Memory write data |
| mem_rd_valid | input | 1 | Read data beat returned |
| mem_rd_data | input | DATA_W | Read data beat |

## Verification
The bench sweeps every line and every starting offset. It counts the memory beats seen before the response, so a design that waits for the whole block, or forwards the wrong beat, gives a wrong beat count or wrong data. It dirties a line and then displaces it, checking the memory image afterwards: a write-back design that skips the copy loses the stored value, and one that always copies shows extra writes on clean evictions. A write miss followed by a read of the same address exposes a design that wrongly allocates on a write miss, because the expected four-beat fill would then be missing. Both policy settings run side by side against a memory model that stalls every third cycle, which catches request fields that change while stalled.

// File: rtl/lt_cache_pkg.sv
package lt_cache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVICT,
        ST_FILL_REQ,
        ST_FILL_WAIT,
        ST_MEMWR
    } ctl_state_e;

endpackage

// File: rtl/lt_cache_tags.sv
module lt_cache_tags #(
    parameter int LINES = 16,
    parameter int TAG_W = 4,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic             wr_dirty,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [LINES-1:0] valid_q, valid_d;
    logic [LINES-1:0] dirty_q, dirty_d;
    logic [TAG_W-1:0] tag_q [LINES];
    logic [TAG_W-1:0] tag_d [LINES];

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        tag_d   = tag_q;
        if (wr_en) begin
            valid_d[wr_idx] = wr_valid;
            dirty_d[wr_idx] = wr_dirty;
            tag_d[wr_idx]   = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/lt_cache_data.sv
module lt_cache_data #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] word_q [DEPTH];
    logic [DATA_W-1:0] word_d [DEPTH];

    always_comb begin
        word_d = word_q;
        if (wr_en) begin
            word_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        word_q <= word_d;
    end

    assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/lt_cache.sv
module lt_cache
    import lt_cache_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 32,
    parameter int LINES      = 16,
    parameter int WORDS      = 4,
    parameter int WRITE_BACK = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(WORDS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int DEPTH = LINES * WORDS;
    localparam int DA_W  = IDX_W + OFF_W;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

    typedef struct packed {
        ctl_state_e        state;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [OFF_W-1:0]  beat;
        logic              rsp;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    // address fields of the incoming and the held request
    logic [TAG_W-1:0] c_tag, s_tag;
    logic [IDX_W-1:0] c_idx, s_idx;
    logic [OFF_W-1:0] c_off, s_off;

    assign c_tag = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign c_idx = cpu_req_addr[OFF_W +: IDX_W];
    assign c_off = cpu_req_addr[OFF_W-1:0];
    assign s_tag = ctl_q.addr[ADDR_W-1 -: TAG_W];
    assign s_idx = ctl_q.addr[OFF_W +: IDX_W];
    assign s_off = ctl_q.addr[OFF_W-1:0];

    logic in_idle;
    assign in_idle = (ctl_q.state == ST_IDLE);

    // policy selection
    logic wb_mode;
    generate
        if (WRITE_BACK != 0) begin : g_wb
            assign wb_mode = 1'b1;
        end else begin : g_wt
            assign wb_mode = 1'b0;
        end
    endgenerate

    // tag store
    logic [IDX_W-1:0] look_idx;
    logic             t_valid, t_dirty;
    logic [TAG_W-1:0] t_tag;
    logic             tag_we, tag_wv, tag_wd;
    logic [TAG_W-1:0] tag_wt;

    assign look_idx = in_idle ? c_idx : s_idx;

    lt_cache_tags #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (look_idx),
        .rd_valid (t_valid),
        .rd_dirty (t_dirty),
        .rd_tag   (t_tag),
        .wr_en    (tag_we),
        .wr_idx   (look_idx),
        .wr_valid (tag_wv),
        .wr_dirty (tag_wd),
        .wr_tag   (tag_wt)
    );

    // data store
    logic [DA_W-1:0]   dat_ra, dat_wa;
    logic [DATA_W-1:0] dat_rd, dat_wd;
    logic              dat_we;

    assign dat_ra = in_idle ? {c_idx, c_off} : {s_idx, ctl_q.beat};

    lt_cache_data #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_data (
        .clk     (clk),
        .rd_addr (dat_ra),
        .rd_data (dat_rd),
        .wr_en   (dat_we),
        .wr_addr (dat_wa),
        .wr_data (dat_wd)
    );

    logic hit;
    assign hit = t_valid && (t_tag == c_tag);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rsp = 1'b0;
        tag_we    = 1'b0;
        tag_wv    = 1'b1;
        tag_wd    = 1'b0;
        tag_wt    = s_tag;
        dat_we    = 1'b0;
        dat_wa    = {s_idx, ctl_q.beat};
        dat_wd    = mem_rd_data;

        case (ctl_q.state)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    ctl_d.write = cpu_req_write;
                    ctl_d.addr  = cpu_req_addr;
                    ctl_d.wdata = cpu_req_wdata;
                    ctl_d.beat  = '0;
                    if (cpu_req_write) begin
                        if (hit) begin
                            dat_we = 1'b1;
                            dat_wa = {c_idx, c_off};
                            dat_wd = cpu_req_wdata;
                            if (wb_mode) begin
                                tag_we    = 1'b1;
                                tag_wd    = 1'b1;
                                tag_wt    = c_tag;
                                ctl_d.rsp = 1'b1;
                            end else begin
                                ctl_d.state = ST_MEMWR;
                            end
                        end else begin
                            ctl_d.state = ST_MEMWR;
                        end
                    end else begin
                        if (hit) begin
                            ctl_d.rsp   = 1'b1;
                            ctl_d.rdata = dat_rd;
                        end else if (wb_mode && t_valid && t_dirty) begin
                            ctl_d.state = ST_EVICT;
                        end else begin
                            ctl_d.state = ST_FILL_REQ;
                        end
                    end
                end
            end
            ST_EVICT: begin
                if (mem_req_ready) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) begin
                        ctl_d.state = ST_FILL_REQ;
                    end
                end
            end
            ST_FILL_REQ: begin
                if (mem_req_ready) begin
                    ctl_d.state = ST_FILL_WAIT;
                end
            end
            ST_FILL_WAIT: begin
                if (mem_rd_valid) begin
                    dat_we = 1'b1;
                    if (ctl_q.beat == s_off) begin
                        ctl_d.rsp   = 1'b1;
                        ctl_d.rdata = mem_rd_data;
                    end
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) begin
                        tag_we      = 1'b1;
                        tag_wd      = 1'b0;
                        tag_wt      = s_tag;
                        ctl_d.state = ST_IDLE;
                    end else begin
                        ctl_d.state = ST_FILL_REQ;
                    end
                end
            end
            ST_MEMWR: begin
                if (mem_req_ready) begin
                    ctl_d.rsp   = 1'b1;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{state: ST_IDLE, write: 1'b0, addr: '0, wdata: '0,
                       beat: '0, rsp: 1'b0, rdata: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // port drive
    assign cpu_req_ready  = in_idle;
    assign cpu_resp_valid = ctl_q.rsp;
    assign cpu_resp_rdata = ctl_q.rdata;

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = ctl_q.addr;
        mem_req_wdata = ctl_q.wdata;
        case (ctl_q.state)
            ST_EVICT: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {t_tag, s_idx, ctl_q.beat};
                mem_req_wdata = dat_rd;
            end
            ST_FILL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {s_tag, s_idx, ctl_q.beat};
            end
            ST_MEMWR: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
            end
            default: begin
                mem_req_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lt_cache_chk.sv
module lt_cache_chk #(
    parameter int ADDR_W     = 10,
    parameter int OFF_W      = 2,
    parameter int WRITE_BACK = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_req_write,
    input logic              cpu_resp_valid,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr
);

    logic             pend_q;
    logic             pend_wr_q;
    logic [OFF_W-1:0] fill_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_wr_q  <= 1'b0;
            fill_cnt_q <= '0;
        end else begin
            if (cpu_req_valid && cpu_req_ready) begin
                pend_q    <= 1'b1;
                pend_wr_q <= cpu_req_write;
            end else if (cpu_resp_valid) begin
                pend_q <= 1'b0;
            end
            if (mem_req_valid && mem_req_ready && !mem_req_write) begin
                fill_cnt_q <= fill_cnt_q + 1'b1;
            end
        end
    end

    AST_RESP_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |-> pend_q); // R9

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !cpu_req_ready); // R9

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))); // R9

    AST_FILL_ORDER: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready && !mem_req_write) |->
            (mem_req_addr[OFF_W-1:0] == fill_cnt_q)); // R2

    AST_WT_NO_EVICT: assert property (@(posedge clk) disable iff (rst)
        (WRITE_BACK == 0 && mem_req_valid && mem_req_write) |-> pend_wr_q); // R7

endmodule

bind lt_cache lt_cache_chk #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .WRITE_BACK (WRITE_BACK)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cpu_req_valid  (cpu_req_valid),
    .cpu_req_ready  (cpu_req_ready),
    .cpu_req_write  (cpu_req_write),
    .cpu_resp_valid (cpu_resp_valid),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_write  (mem_req_write),
    .mem_req_addr   (mem_req_addr)
);

// File: tb/lt_cache_bench.sv
`timescale 1ns/1ps

module lt_cache_memsim (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [9:0]  req_addr,
    input  logic [31:0] req_wdata,
    output logic        req_ready,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    input  logic [9:0]  peek_addr,
    output logic [31:0] peek_data,
    output int          n_rd,
    output int          n_wr,
    output int          n_beat,
    output logic [9:0]  last_wr_addr,
    output logic [31:0] last_wr_data,
    output logic        rd_order_bad
);
    logic [31:0] mem [1024];
    int          cyc;
    int          pend;
    logic [9:0]  paddr;
    logic [7:0]  prev_blk;

    initial begin
        for (int a = 0; a < 1024; a++) mem[a] = 32'h5A5A0000 + a * 32'h00010001;
    end

    assign req_ready = (cyc % 3) != 1;
    assign peek_data = mem[peek_addr];

    always @(posedge clk) begin
        if (rst) begin
            cyc <= 0; pend <= 0; n_rd <= 0; n_wr <= 0; n_beat <= 0;
            rd_valid <= 1'b0; rd_data <= '0; paddr <= '0; prev_blk <= '0;
            rd_order_bad <= 1'b0; last_wr_addr <= '0; last_wr_data <= '0;
        end else begin
            cyc <= cyc + 1;
            rd_valid <= 1'b0;
            if (rd_valid) n_beat <= n_beat + 1;
            if (pend == 2) begin
                pend <= 1;
            end else if (pend == 1) begin
                pend <= 0;
                rd_valid <= 1'b1;
                rd_data <= mem[paddr];
            end
            if (req_valid && req_ready) begin
                if (req_write) begin
                    mem[req_addr] <= req_wdata;
                    n_wr <= n_wr + 1;
                    last_wr_addr <= req_addr;
                    last_wr_data <= req_wdata;
                end else begin
                    pend <= 2;
                    paddr <= req_addr;
                    n_rd <= n_rd + 1;
                    if (req_addr[1:0] != 2'(n_rd % 4)) rd_order_bad <= 1'b1;
                    if ((n_rd % 4) != 0 && req_addr[9:2] != prev_blk) rd_order_bad <= 1'b1;
                    prev_blk <= req_addr[9:2];
                end
            end
        end
    end
endmodule

module lt_cache_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        c_valid [2];
    logic        c_write [2];
    logic [9:0]  c_addr  [2];
    logic [31:0] c_wdata [2];
    logic        c_ready [2];
    logic        r_valid [2];
    logic [31:0] r_data  [2];
    logic        m_valid [2];
    logic        m_write [2];
    logic [9:0]  m_addr  [2];
    logic [31:0] m_wdata [2];
    logic        m_ready [2];
    logic        m_rdv   [2];
    logic [31:0] m_rdd   [2];
    logic [9:0]  pk_addr [2];
    logic [31:0] pk_data [2];
    int          n_rd    [2];
    int          n_wr    [2];
    int          n_beat  [2];
    logic [9:0]  last_wa [2];
    logic [31:0] last_wd [2];
    logic        ord_bad [2];

    logic [31:0] sh [2][1024];

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 0;

    lt_cache #(.WRITE_BACK(1)) u_lt_cache (
        .clk(clk), .rst(rst),
        .cpu_req_valid(c_valid[0]), .cpu_req_ready(c_ready[0]),
        .cpu_req_write(c_write[0]), .cpu_req_addr(c_addr[0]),
        .cpu_req_wdata(c_wdata[0]), .cpu_resp_valid(r_valid[0]),
        .cpu_resp_rdata(r_data[0]),
        .mem_req_valid(m_valid[0]), .mem_req_ready(m_ready[0]),
        .mem_req_write(m_write[0]), .mem_req_addr(m_addr[0]),
        .mem_req_wdata(m_wdata[0]), .mem_rd_valid(m_rdv[0]),
        .mem_rd_data(m_rdd[0])
    );

    lt_cache #(.WRITE_BACK(0)) u_lt_cache_wt (
        .clk(clk), .rst(rst),
        .cpu_req_valid(c_valid[1]), .cpu_req_ready(c_ready[1]),
        .cpu_req_write(c_write[1]), .cpu_req_addr(c_addr[1]),
        .cpu_req_wdata(c_wdata[1]), .cpu_resp_valid(r_valid[1]),
        .cpu_resp_rdata(r_data[1]),
        .mem_req_valid(m_valid[1]), .mem_req_ready(m_ready[1]),
        .mem_req_write(m_write[1]), .mem_req_addr(m_addr[1]),
        .mem_req_wdata(m_wdata[1]), .mem_rd_valid(m_rdv[1]),
        .mem_rd_data(m_rdd[1])
    );

    for (genvar g = 0; g < 2; g++) begin : g_mem
        lt_cache_memsim u_mem (
            .clk(clk), .rst(rst),
            .req_valid(m_valid[g]), .req_write(m_write[g]),
            .req_addr(m_addr[g]), .req_wdata(m_wdata[g]),
            .req_ready(m_ready[g]), .rd_valid(m_rdv[g]), .rd_data(m_rdd[g]),
            .peek_addr(pk_addr[g]), .peek_data(pk_data[g]),
            .n_rd(n_rd[g]), .n_wr(n_wr[g]), .n_beat(n_beat[g]),
            .last_wr_addr(last_wa[g]), .last_wr_data(last_wd[g]),
            .rd_order_bad(ord_bad[g])
        );
    end

    task automatic chk(input string r, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    task automatic wait_idle(input int k);
        while (!c_ready[k]) @(negedge clk);
    endtask

    task automatic peek(input int k, input logic [9:0] a, output logic [31:0] v);
        pk_addr[k] = a;
        #0.5;
        v = pk_data[k];
    endtask

    task automatic cpu_op(input int k, input bit wr, input logic [9:0] a,
                          input logic [31:0] d, output logic [31:0] q,
                          output int lat, output bit busy_ok);
        @(negedge clk);
        c_valid[k] = 1'b1; c_write[k] = wr; c_addr[k] = a; c_wdata[k] = d;
        while (!c_ready[k]) @(negedge clk);
        @(negedge clk);
        c_valid[k] = 1'b0;
        lat = 1;
        busy_ok = 1'b1;
        while (!r_valid[k] && lat < 300) begin
            if (c_ready[k]) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        q = r_data[k];
    endtask

    task automatic run_suite(input int k, input bit wb);
        logic [31:0] q, v;
        int lat, rd0, wr0, bt0;
        bit bz;
        string tg;
        tg = wb ? "wb" : "wt";

        chk("R10", {tg, " ready after reset"}, 32'(c_ready[k]), 32'd1);
        chk("R10", {tg, " no response after reset"}, 32'(r_valid[k]), 32'd0);

        rd0 = n_rd[k]; bt0 = n_beat[k]; wr0 = n_wr[k];
        cpu_op(k, 1'b0, 10'h005, 32'h0, q, lat, bz);
        chk("R3", {tg, " first miss data"}, q, sh[k][10'h005]);
        chk("R3", {tg, " beats before response"}, 32'(n_beat[k] - bt0), 32'd2);
        chk("R3", {tg, " still filling at response"}, 32'(c_ready[k]), 32'd0);
        chk("R10", {tg, " first read misses"}, 32'(lat > 1), 32'd1);
        chk("R9", {tg, " not ready while busy"}, 32'(bz), 32'd1);
        wait_idle(k);
        chk("R2", {tg, " fill reads"}, 32'(n_rd[k] - rd0), 32'd4);
        chk("R2", {tg, " fill order"}, 32'(ord_bad[k]), 32'd0);
        chk("R7", {tg, " no write on invalid line"}, 32'(n_wr[k] - wr0), 32'd0);

        for (int idx = 0; idx < 16; idx++) begin
            for (int j = 0; j < 4; j++) begin
                int off;
                logic [9:0] a;
                bit hit_exp;
                off = (j + idx) % 4;
                a = 10'(idx * 4 + off);
                hit_exp = (j > 0) || (idx == 1);
                rd0 = n_rd[k]; bt0 = n_beat[k];
                cpu_op(k, 1'b0, a, 32'h0, q, lat, bz);
                chk("R1", $sformatf("%s sweep data @%h", tg, a), q, sh[k][a]);
                if (hit_exp) begin
                    chk("R1", $sformatf("%s hit latency @%h", tg, a), 32'(lat), 32'd1);
                    chk("R1", $sformatf("%s hit no mem @%h", tg, a), 32'(n_rd[k] - rd0), 32'd0);
                end else begin
                    chk("R3", $sformatf("%s beats @%h", tg, a), 32'(n_beat[k] - bt0), 32'(off + 1));
                    chk("R3", $sformatf("%s ready @%h", tg, a), 32'(c_ready[k]), 32'(off == 3));
                    wait_idle(k);
                    chk("R2", $sformatf("%s reads @%h", tg, a), 32'(n_rd[k] - rd0), 32'd4);
                end
            end
        end
        chk("R2", {tg, " sweep order"}, 32'(ord_bad[k]), 32'd0);

        wr0 = n_wr[k];
        cpu_op(k, 1'b1, 10'h006, 32'hDEAD0006, q, lat, bz);
        peek(k, 10'h006, v);
        if (wb) begin
            chk("R5", "write hit latency", 32'(lat), 32'd1);
            chk("R5", "write hit no mem write", 32'(n_wr[k] - wr0), 32'd0);
            chk("R5", "memory stale", v, sh[k][10'h006]);
        end else begin
            chk("R4", "write hit mem writes", 32'(n_wr[k] - wr0), 32'd1);
            chk("R4", "write hit mem addr", 32'(last_wa[k]), 32'h006);
            chk("R4", "write hit mem data", last_wd[k], 32'hDEAD0006);
            chk("R4", "memory updated", v, 32'hDEAD0006);
            chk("R9", "busy during write", 32'(bz), 32'd1);
        end
        sh[k][10'h006] = 32'hDEAD0006;
        wait_idle(k);
        cpu_op(k, 1'b0, 10'h006, 32'h0, q, lat, bz);
        chk(wb ? "R5" : "R4", {tg, " read after write hit"}, q, 32'hDEAD0006);
        chk(wb ? "R5" : "R4", {tg, " read after write hit latency"}, 32'(lat), 32'd1);

        wr0 = n_wr[k]; rd0 = n_rd[k];
        cpu_op(k, 1'b0, 10'h046, 32'h0, q, lat, bz);
        wait_idle(k);
        chk(wb ? "R6" : "R7", {tg, " evict read data"}, q, sh[k][10'h046]);
        chk(wb ? "R6" : "R2", {tg, " evict fill reads"}, 32'(n_rd[k] - rd0), 32'd4);
        if (wb) begin
            chk("R6", "dirty copy writes", 32'(n_wr[k] - wr0), 32'd4);
            chk("R6", "last copy addr", 32'(last_wa[k]), 32'h007);
            peek(k, 10'h006, v);
            chk("R6", "copied word in memory", v, 32'hDEAD0006);
            peek(k, 10'h004, v);
            chk("R6", "clean word in memory", v, sh[k][10'h004]);
        end else begin
            chk("R7", "no writes on wt miss", 32'(n_wr[k] - wr0), 32'd0);
        end

        wr0 = n_wr[k];
        cpu_op(k, 1'b0, 10'h086, 32'h0, q, lat, bz);
        wait_idle(k);
        chk("R7", {tg, " clean replace data"}, q, sh[k][10'h086]);
        chk("R7", {tg, " clean replace no writes"}, 32'(n_wr[k] - wr0), 32'd0);

        wr0 = n_wr[k]; rd0 = n_rd[k];
        cpu_op(k, 1'b1, 10'h200, 32'hBEEF0200, q, lat, bz);
        wait_idle(k);
        sh[k][10'h200] = 32'hBEEF0200;
        peek(k, 10'h200, v);
        chk("R8", {tg, " write miss one write"}, 32'(n_wr[k] - wr0), 32'd1);
        chk("R8", {tg, " write miss no read"}, 32'(n_rd[k] - rd0), 32'd0);
        chk("R8", {tg, " write miss addr"}, 32'(last_wa[k]), 32'h200);
        chk("R8", {tg, " write miss memory"}, v, 32'hBEEF0200);
        rd0 = n_rd[k];
        cpu_op(k, 1'b0, 10'h200, 32'h0, q, lat, bz);
        wait_idle(k);
        chk("R8", {tg, " not allocated"}, 32'(n_rd[k] - rd0), 32'd4);
        chk("R8", {tg, " read back"}, q, 32'hBEEF0200);
    endtask

    initial begin
        for (int k = 0; k < 2; k++) begin
            c_valid[k] = 1'b0; c_write[k] = 1'b0; c_addr[k] = '0;
            c_wdata[k] = '0; pk_addr[k] = '0;
            for (int a = 0; a < 1024; a++) sh[k][a] = 32'h5A5A0000 + a * 32'h00010001;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        run_suite(0, 1'b1);
        run_suite(1, 1'b0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule